// File: doc/BRIEF.md
# Multi-Page-Size Second-Level TLB

This block is a unified second-level translation cache. It sits behind the small first-level instruction and data TLBs and receives the misses of both. Virtual-to-physical mappings of six page sizes share one set-associative array: 4KB, 64KB, 1MB, 2MB, 16MB and 512MB. The default array has 512 entries in 4 ways, which gives 128 sets.

Every entry is placed in a set chosen by the address bits just above its own page offset. An entry of unknown size can therefore be in any of six places. A lookup probes one page size per cycle, starting with the smallest. It stops at the first hit, or reports a miss once all six sizes have been tried.

Fills arrive on a separate request port. A 1GB block is never stored whole. Only the 512MB half that contains the fill address is written. Lookup and fill share the single array port. A fill that arrives during a lookup is held until the lookup completes.

Top module: `mtlb_l2`

## Requirements
- R1: After reset, `lk_ready_o` and `fl_ready_o` are 1, `lk_done_o` is 0, and every lookup misses.
- R2: A lookup is accepted on a clock edge where both `lk_req_i` and `lk_ready_o` are 1. Size codes 0 to 5 are probed in ascending order, one per cycle. A hit on size code s raises `lk_done_o` for exactly one cycle, s+1 clock edges after the accepting edge. A miss raises it 6 edges after the accepting edge, with `lk_hit_o` = 0.
- R3: On a hit, `lk_pa_o` holds the stored physical base above the page offset and the lookup address bits below the page offset. On a miss, `lk_pa_o` and `lk_size_o` are 0.
- R4: Size codes are 0=4KB, 1=64KB, 2=1MB, 3=2MB, 4=16MB, 5=512MB and 6=1GB. Code 6 is accepted only on a fill. `lk_size_o` reports the code of the entry that hit.
- R5: A fill with code 6 stores a 512MB entry for the half of the 1GB block that holds `fl_va_i`. The physical base gets bit 29 from `fl_va_i`. Lookups in that half hit with size 5. Lookups in the other half miss.
- R6: An entry of page shift k goes to the set indexed by virtual address bits [k+6:k]. Four distinct pages that map to one set are all kept.
- R7: A fill prefers the lowest-numbered invalid way of its set. When the set is full, a per-set pointer picks the victim. The pointer starts at way 0 after reset or flush and advances by one on each such eviction. So the fifth distinct page filled into a full set evicts the first one, and the sixth evicts the second.
- R8: A fill whose page and size already sit in the target set overwrites that entry's physical base. No other entry is evicted.
- R9: A fill request is taken when `fl_ready_o` is 1. It is written in the first cycle the block is neither probing nor being flushed. A lookup that is in progress, or accepted together with the fill, does not see the fill. Later lookups do see it.
- R10: A `flush_i` pulse invalidates every entry at the next edge and discards any fill still pending.
- R11: `lk_ready_o` is 0 from the accepting edge until the done cycle, and also while a fill is pending. `fl_ready_o` is 0 while a fill is pending.
- R12: Pages of different sizes may overlap. The smallest matching size wins, and addresses outside the small page fall through to the larger one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_ready_o | output | 1 | Lookup can be accepted |
| lk_done_o | output | 1 | One-cycle lookup completion |
| lk_hit_o | output | 1 | Lookup hit, valid with done |
| lk_pa_o | output | PA_W | Translated physical address |
| lk_size_o | output | 3 | Size code of hitting entry |
| fl_req_i | input | 1 | Fill request |
| fl_va_i | input | VA_W | Fill virtual address |
| fl_pa_i | input | PA_W | Fill physical base, aligned to the fill size |
| fl_size_i | input | 3 | Fill size code 0..6 |
| fl_ready_o | output | 1 | Fill can be accepted |

## Verification
Each lookup result is due a fixed number of edges after acceptance: size code plus one for a hit, six for a miss. The bench counts negative edges from the acceptance edge until `lk_done_o` and compares that count with the expected latency for each vector. A fill becomes visible two edges after its request when the block is idle, or one edge after the done cycle of a lookup it collided with. The bench waits on `fl_ready_o` before the next lookup and samples the ready flags at the negative edge right after a collision.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int NSIZES = 6;
  localparam int SZ_W   = 3;

  typedef enum logic [SZ_W-1:0] {
    PG_4K   = 3'd0,
    PG_64K  = 3'd1,
    PG_1M   = 3'd2,
    PG_2M   = 3'd3,
    PG_16M  = 3'd4,
    PG_512M = 3'd5,
    PG_1G   = 3'd6
  } pg_size_e;

  function automatic int unsigned page_shift(logic [SZ_W-1:0] code);
    case (code)
      3'd0:    return 12;
      3'd1:    return 16;
      3'd2:    return 20;
      3'd3:    return 21;
      3'd4:    return 24;
      3'd5:    return 29;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int SETS  = 128,
  parameter int VPN_W = 28,
  parameter int PPN_W = 28,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             we_i,
  input  logic [2:0]       wr_size_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  output logic             rd_valid_o,
  output logic [2:0]       rd_size_o,
  output logic [VPN_W-1:0] rd_vpn_o,
  output logic [PPN_W-1:0] rd_ppn_o
);
  logic [SETS-1:0]  valid_q;
  logic [2:0]       size_q [SETS];
  logic [VPN_W-1:0] vpn_q  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (we_i) begin
      valid_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i && !flush_i) begin
      size_q[idx_i] <= wr_size_i;
      vpn_q[idx_i]  <= wr_vpn_i;
      ppn_q[idx_i]  <= wr_ppn_i;
    end
  end

  assign rd_valid_o = valid_q[idx_i];
  assign rd_size_o  = size_q[idx_i];
  assign rd_vpn_o   = vpn_q[idx_i];
  assign rd_ppn_o   = ppn_q[idx_i];

  assert_flush_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int WAYS  = 4,
  parameter int VPN_W = 28,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][2:0]        size_i,
  input  logic [WAYS-1:0][VPN_W-1:0]  vpn_i,
  input  logic [2:0]                  fsize_i,
  input  logic [VPN_W-1:0]            fvpn_i,
  input  logic [WAY_W-1:0]            rr_i,
  output logic [WAYS-1:0]             match_o,
  output logic [WAYS-1:0]             sel_o,
  output logic                        adv_rr_o
);
  logic [WAYS-1:0] match_first, free_first;

  for (genvar g = 0; g < WAYS; g++) begin : g_match
    assign match_o[g] = valid_i[g] && (size_i[g] == fsize_i) && (vpn_i[g] == fvpn_i);
  end

  always_comb begin
    match_first = '0;
    free_first  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) match_first = WAYS'(1) << w;
      if (!valid_i[w]) free_first = WAYS'(1) << w;
    end
  end

  always_comb begin
    adv_rr_o = 1'b0;
    if (|match_o)       sel_o = match_first;
    else if (~&valid_i) sel_o = free_first;
    else begin
      sel_o    = WAYS'(1) << rr_i;
      adv_rr_o = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_probe_fsm.sv
module tlb_probe_fsm #(
  parameter int NSIZES = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       hit_i,
  output logic       busy_o,
  output logic [2:0] size_o,
  output logic       cap_o,
  output logic       done_o,
  output logic       hit_o
);
  localparam logic [2:0] LAST = 3'(NSIZES - 1);

  logic       busy_q, done_q, hit_q;
  logic [2:0] idx_q;

  assign cap_o  = busy_q && (hit_i || idx_q == LAST);
  assign busy_o = busy_q;
  assign size_o = idx_q;
  assign done_o = done_q;
  assign hit_o  = hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      done_q <= cap_o;
      if (cap_o) hit_q <= hit_i;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (cap_o) busy_q <= 1'b0;
        else       idx_q  <= idx_q + 3'd1;
      end
    end
  end

  assert_done_follows_probe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(busy_q));
  assert_miss_tries_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !hit_q) |-> ($past(idx_q) == LAST));
  assert_size_ascends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !cap_o) |=> (idx_q == $past(idx_q) + 3'd1));
endmodule

// File: rtl/mtlb_l2.sv
module mtlb_l2
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int WAYS    = 4,
  parameter int VA_W    = 40,
  parameter int PA_W    = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            lk_req_i,
  input  logic [VA_W-1:0] lk_va_i,
  output logic            lk_ready_o,
  output logic            lk_done_o,
  output logic            lk_hit_o,
  output logic [PA_W-1:0] lk_pa_o,
  output logic [2:0]      lk_size_o,
  input  logic            fl_req_i,
  input  logic [VA_W-1:0] fl_va_i,
  input  logic [PA_W-1:0] fl_pa_i,
  input  logic [2:0]      fl_size_i,
  output logic            fl_ready_o
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int VPN_W = VA_W - 12;
  localparam int PPN_W = PA_W - 12;

  // pending fill
  logic            pend_q;
  logic [VA_W-1:0] pend_va_q;
  logic [PA_W-1:0] pend_pa_q;
  logic [2:0]      pend_sz_q;

  // lookup state
  logic [VA_W-1:0] va_q;
  logic            busy, cap, accept, fill_go;
  logic [2:0]      probe_sz;

  // array read
  logic [IDX_W-1:0]             idx;
  logic [WAYS-1:0]              rd_valid;
  logic [WAYS-1:0][2:0]         rd_size;
  logic [WAYS-1:0][VPN_W-1:0]   rd_vpn;
  logic [WAYS-1:0][PPN_W-1:0]   rd_ppn;

  logic [VPN_W-1:0] p_vpn, f_vpn;
  logic [PPN_W-1:0] f_ppn, hit_ppn;
  logic [PA_W-1:0]  f_pa;
  logic [2:0]       f_sz;
  logic [WAYS-1:0]  way_hit, fill_match, fill_sel;
  logic             hit_any, adv_rr;
  logic [PA_W-1:0]  pa_q;
  logic [2:0]       sz_q;
  logic [WAY_W-1:0] rr_q [SETS];

  assign lk_ready_o = !busy && !pend_q;
  assign fl_ready_o = !pend_q;
  assign accept     = lk_req_i && lk_ready_o;
  assign fill_go    = !busy && pend_q && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      pend_va_q <= '0;
      pend_pa_q <= '0;
      pend_sz_q <= '0;
      va_q      <= '0;
    end else begin
      if (flush_i || fill_go) pend_q <= 1'b0;
      else if (fl_req_i && !pend_q) begin
        pend_q    <= 1'b1;
        pend_va_q <= fl_va_i;
        pend_pa_q <= fl_pa_i;
        pend_sz_q <= fl_size_i;
      end
      if (accept) va_q <= lk_va_i;
    end
  end

  // a 1GB block is cut to the 512MB half that holds the fill address
  always_comb begin
    f_pa = pend_pa_q;
    f_sz = pend_sz_q;
    if (pend_sz_q >= PG_1G) begin
      f_sz     = PG_512M;
      f_pa[29] = pend_va_q[29];
    end
  end

  assign f_vpn = VPN_W'(pend_va_q >> page_shift(f_sz));
  assign f_ppn = PPN_W'(f_pa >> 12);
  assign p_vpn = VPN_W'(va_q >> page_shift(probe_sz));
  assign idx   = fill_go ? f_vpn[IDX_W-1:0] : p_vpn[IDX_W-1:0];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlb_way_store #(.SETS(SETS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .idx_i      (idx),
      .we_i       (fill_go && fill_sel[g]),
      .wr_size_i  (f_sz),
      .wr_vpn_i   (f_vpn),
      .wr_ppn_i   (f_ppn),
      .rd_valid_o (rd_valid[g]),
      .rd_size_o  (rd_size[g]),
      .rd_vpn_o   (rd_vpn[g]),
      .rd_ppn_o   (rd_ppn[g])
    );
    assign way_hit[g] = busy && rd_valid[g] && (rd_size[g] == probe_sz) && (rd_vpn[g] == p_vpn);
  end

  assign hit_any = |way_hit;

  always_comb begin
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) if (way_hit[w]) hit_ppn = rd_ppn[w];
  end

  tlb_victim_pick #(.WAYS(WAYS), .VPN_W(VPN_W)) u_victim (
    .valid_i  (rd_valid),
    .size_i   (rd_size),
    .vpn_i    (rd_vpn),
    .fsize_i  (f_sz),
    .fvpn_i   (f_vpn),
    .rr_i     (rr_q[idx]),
    .match_o  (fill_match),
    .sel_o    (fill_sel),
    .adv_rr_o (adv_rr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (fill_go && adv_rr) begin
      rr_q[idx] <= rr_q[idx] + WAY_W'(1);
    end
  end

  tlb_probe_fsm #(.NSIZES(NSIZES)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .hit_i   (hit_any),
    .busy_o  (busy),
    .size_o  (probe_sz),
    .cap_o   (cap),
    .done_o  (lk_done_o),
    .hit_o   (lk_hit_o)
  );

  function automatic logic [PA_W-1:0] join_pa(logic [PPN_W-1:0] ppn, logic [VA_W-1:0] va,
                                              int unsigned sh);
    logic [PA_W-1:0] m;
    m = (PA_W'(1) << sh) - PA_W'(1);
    return ({ppn, 12'h000} & ~m) | (PA_W'(va) & m);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= '0;
      sz_q <= '0;
    end else if (cap) begin
      pa_q <= hit_any ? join_pa(hit_ppn, va_q, page_shift(probe_sz)) : '0;
      sz_q <= hit_any ? probe_sz : 3'd0;
    end
  end

  assign lk_pa_o   = pa_q;
  assign lk_size_o = sz_q;

  assert_probe_hit_unique_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> $onehot0(way_hit));
  assert_no_duplicate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |-> $onehot0(fill_match));
  assert_victim_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |-> $onehot(fill_sel));
  assert_fill_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && busy && !flush_i) |=> pend_q);
  assert_size_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && lk_hit_o) |-> (lk_size_o <= 3'd5));
endmodule

// File: tb/sim_mtlb_l2.sv
module sim_mtlb_l2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_req = 1'b0;
  logic [39:0] lk_va = '0;
  logic        lk_ready, lk_done, lk_hit;
  logic [39:0] lk_pa;
  logic [2:0]  lk_size;
  logic        fl_req = 1'b0;
  logic [39:0] fl_va = '0;
  logic [39:0] fl_pa = '0;
  logic [2:0]  fl_size = '0;
  logic        fl_ready;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mtlb_l2 u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lk_req_i(lk_req), .lk_va_i(lk_va), .lk_ready_o(lk_ready), .lk_done_o(lk_done),
    .lk_hit_o(lk_hit), .lk_pa_o(lk_pa), .lk_size_o(lk_size),
    .fl_req_i(fl_req), .fl_va_i(fl_va), .fl_pa_i(fl_pa), .fl_size_i(fl_size),
    .fl_ready_o(fl_ready)
  );

  typedef struct packed {
    logic        fill;
    logic [39:0] va;
    logic [39:0] pa;   // fill base or expected lookup address
    logic [2:0]  sz;
    logic        hit;
    logic [3:0]  lat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 40'h00_1234_5000, 40'h00_ABCD_E000, 3'd0, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h00_1234_5678, 40'h00_ABCD_E678, 3'd0, 1'b1, 4'd1, 4'd3},  // R3
    '{1'b0, 40'h00_1234_6678, 40'h00_0000_0000, 3'd0, 1'b0, 4'd6, 4'd2},  // R2
    '{1'b1, 40'h00_4000_0000, 40'h00_8000_0000, 3'd3, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h00_401F_FFFC, 40'h00_801F_FFFC, 3'd3, 1'b1, 4'd4, 4'd3},  // R3
    '{1'b1, 40'h00_0777_0000, 40'h01_2345_0000, 3'd1, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h00_0777_ABCD, 40'h01_2345_ABCD, 3'd1, 1'b1, 4'd2, 4'd2},  // R2
    '{1'b1, 40'h00_0A00_0000, 40'h00_0550_0000, 3'd2, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h00_0A0F_1234, 40'h00_055F_1234, 3'd2, 1'b1, 4'd3, 4'd2},  // R2
    '{1'b1, 40'h00_3000_0000, 40'h00_1100_0000, 3'd4, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h00_30AB_CDEF, 40'h00_11AB_CDEF, 3'd4, 1'b1, 4'd5, 4'd2},  // R2
    '{1'b1, 40'h20_0000_0000, 40'h40_0000_0000, 3'd5, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h20_1234_5678, 40'h40_1234_5678, 3'd5, 1'b1, 4'd6, 4'd4},  // R4
    '{1'b1, 40'h80_6000_1000, 40'hC0_0000_0000, 3'd6, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h80_7000_0004, 40'hC0_3000_0004, 3'd5, 1'b1, 4'd6, 4'd5},  // R5
    '{1'b0, 40'h80_4000_0004, 40'h00_0000_0000, 3'd0, 1'b0, 4'd6, 4'd5},  // R5
    '{1'b1, 40'h00_4010_0000, 40'h00_9999_9000, 3'd0, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h00_4010_0ABC, 40'h00_9999_9ABC, 3'd0, 1'b1, 4'd1, 4'd12}, // R12
    '{1'b0, 40'h00_4010_1ABC, 40'h00_8010_1ABC, 3'd3, 1'b1, 4'd4, 4'd12}, // R12
    '{1'b1, 40'h00_1234_5000, 40'h00_7777_7000, 3'd0, 1'b0, 4'd0, 4'd0},
    '{1'b0, 40'h00_1234_5010, 40'h00_7777_7010, 3'd0, 1'b1, 4'd1, 4'd8}   // R8
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [39:0] va, input logic [39:0] pa, input logic [2:0] sz);
    @(negedge clk);
    while (!fl_ready) @(negedge clk);
    fl_va = va; fl_pa = pa; fl_size = sz; fl_req = 1'b1;
    @(negedge clk);
    fl_req = 1'b0;
    while (!fl_ready) @(negedge clk);
  endtask

  task automatic wait_done(output logic hit, output logic [39:0] pa, output logic [2:0] sz,
                           output int lat);
    lat = 0;
    while (!lk_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    hit = lk_hit; pa = lk_pa; sz = lk_size;
  endtask

  task automatic do_lookup(input logic [39:0] va, output logic hit, output logic [39:0] pa,
                           output logic [2:0] sz, output int lat);
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    lk_va = va; lk_req = 1'b1;
    @(negedge clk);
    lk_req = 1'b0;
    wait_done(hit, pa, sz, lat);
  endtask

  task automatic expect_lookup(input logic [39:0] va, input bit ehit, input logic [39:0] epa,
                               input logic [2:0] esz, input int elat, input string req);
    logic hit; logic [39:0] pa; logic [2:0] sz; int lat;
    do_lookup(va, hit, pa, sz, lat);
    check(hit == ehit && pa == epa && sz == esz && lat == elat, req,
          {hit, 3'b0, sz, 4'b0, lat[7:0], pa[39:0]},
          {ehit, 3'b0, esz, 4'b0, 8'(elat), epa});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(lk_ready && fl_ready && !lk_done, "R1", {61'b0, lk_ready, fl_ready, lk_done}, 64'h6);
    rst_n = 1'b1;
    @(negedge clk);
    check(lk_ready && fl_ready && !lk_done, "R1", {61'b0, lk_ready, fl_ready, lk_done}, 64'h6);
    expect_lookup(40'h00_1234_5678, 1'b0, '0, 3'd0, 6, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].fill) do_fill(VECS[i].va, VECS[i].pa, VECS[i].sz);
      else expect_lookup(VECS[i].va, VECS[i].hit, VECS[i].pa, VECS[i].sz,
                         int'(VECS[i].lat), $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R10 flush invalidates everything
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    expect_lookup(40'h00_1234_5010, 1'b0, '0, 3'd0, 6, "R10");
    expect_lookup(40'h20_1234_5678, 1'b0, '0, 3'd0, 6, "R10");

    // R6 / R7: six 4KB pages into set 5
    for (int k = 1; k <= 4; k++) do_fill((40'(k) << 19) | 40'h5000, 40'(k) << 24, 3'd0);
    for (int k = 1; k <= 4; k++)
      expect_lookup((40'(k) << 19) | 40'h5123, 1'b1, (40'(k) << 24) | 40'h123, 3'd0, 1, "R6");
    do_fill((40'd5 << 19) | 40'h5000, 40'd5 << 24, 3'd0);
    expect_lookup((40'd1 << 19) | 40'h5123, 1'b0, '0, 3'd0, 6, "R7");
    expect_lookup((40'd5 << 19) | 40'h5123, 1'b1, (40'd5 << 24) | 40'h123, 3'd0, 1, "R7");
    do_fill((40'd6 << 19) | 40'h5000, 40'd6 << 24, 3'd0);
    expect_lookup((40'd2 << 19) | 40'h5123, 1'b0, '0, 3'd0, 6, "R7");
    expect_lookup((40'd3 << 19) | 40'h5123, 1'b1, (40'd3 << 24) | 40'h123, 3'd0, 1, "R7");

    // R8 refill present page: no eviction
    do_fill((40'd4 << 19) | 40'h5000, 40'hAB_0000_0000, 3'd0);
    expect_lookup((40'd4 << 19) | 40'h5123, 1'b1, 40'hAB_0000_0123, 3'd0, 1, "R8");
    for (int k = 3; k <= 6; k++)
      if (k != 4)
        expect_lookup((40'(k) << 19) | 40'h5123, 1'b1, (40'(k) << 24) | 40'h123, 3'd0, 1, "R8");

    // R9 / R11 fill colliding with a lookup
    begin
      logic hit; logic [39:0] pa; logic [2:0] sz; int lat;
      @(negedge clk);
      while (!lk_ready) @(negedge clk);
      lk_va = 40'h00_0F00_0044; lk_req = 1'b1;
      fl_va = 40'h00_0F00_0000; fl_pa = 40'h00_0123_4000; fl_size = 3'd0; fl_req = 1'b1;
      @(negedge clk);
      lk_req = 1'b0; fl_req = 1'b0;
      check(!lk_ready && !fl_ready, "R11", {62'b0, lk_ready, fl_ready}, 64'h0);
      wait_done(hit, pa, sz, lat);
      check(!hit && lat == 6, "R9", {55'b0, hit, lat[7:0]}, 64'h6);
      check(!lk_ready, "R11", {63'b0, lk_ready}, 64'h0);
      expect_lookup(40'h00_0F00_0044, 1'b1, 40'h00_0123_4044, 3'd0, 1, "R9");
    end

    // R10 flush discards a pending fill
    begin
      logic hit; logic [39:0] pa; logic [2:0] sz; int lat;
      @(negedge clk);
      while (!lk_ready) @(negedge clk);
      lk_va = 40'h00_0E00_0000; lk_req = 1'b1;
      @(negedge clk);
      lk_req = 1'b0;
      fl_va = 40'h00_0D00_0000; fl_pa = 40'h00_0555_5000; fl_size = 3'd0; fl_req = 1'b1;
      @(negedge clk);
      fl_req = 1'b0; flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      wait_done(hit, pa, sz, lat);
      check(fl_ready, "R10", {63'b0, fl_ready}, 64'h1);
      expect_lookup(40'h00_0D00_0010, 1'b0, '0, 3'd0, 6, "R10");
      expect_lookup(40'h00_0F00_0044, 1'b0, '0, 3'd0, 6, "R10");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule